// File: doc/BRIEF.md
# Power-Management Interval Timer

This block keeps a free-running up-counter that advances at the nominal power-management timer rate of 3,579,545 Hz. That rate is derived from a much faster system clock. A phase accumulator adds a fixed increment on every system clock cycle, and each carry out of the accumulator produces a one-cycle tick enable. The increment is chosen so that the average tick rate matches the target frequency. The block also drives the tick enable as an output, so that neighbouring event logic can share the same time base.

Software accesses the block through a small register slave. A configuration word selects the counter width (24 or 32 bits), can freeze the counter, and can hold it at zero. The count is read as a 32-bit word, zero-extended when the narrow width is selected. The count can also be written, which lets firmware restore a saved value after a power transition. Reads return data one clock after the request, and the returned value stays on the bus until the next read.

Top module: `pm_acpi_timer`

## Requirements
- R1: After reset the count is 0, the configuration word reads 0 (24-bit, running, not held) and `bus_rdata` is 0.
- R2: `tick_pulse` is a single-cycle pulse that is never high on two consecutive cycles. Over N system cycles after reset, the number of pulses is within 2 of N*TICK_HZ/SYS_HZ.
- R3: On each cycle where `tick_pulse` is high and the counter is neither stopped nor held, the count increases by exactly one. On all other cycles it keeps its value, except under R7, R8 and R10.
- R4: With configuration bit 0 clear, the count is 24 bits wide and wraps from 0xFFFFFF to 0. Bits 31:24 of a count read are zero.
- R5: With configuration bit 0 set, the count is 32 bits wide and wraps from 0xFFFFFFFF to 0.
- R6: With configuration bit 1 set, the count holds its value while ticks continue.
- R7: With configuration bit 2 set, the count is forced to 0 and stays there. This takes priority over stop and over a count write. After the bit is cleared, the first tick brings the count to 1.
- R8: Clearing bit 0 while in 32-bit mode truncates the live count to its low 24 bits.
- R9: A read (`bus_sel`=1, `bus_wr`=0) at offset 0x08 returns the count. A read at offset 0x00 returns the configuration in bits 2:0 and zero elsewhere. A read at any other offset returns 0. Data appears on the clock edge that accepts the read and holds until the next read.
- R10: A write at offset 0x08 loads the count, masked to the active width, unless bit 2 is set. A write at offset 0x00 loads bits 2:0 of the configuration. A write at any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tick_pulse | output | 1 | Timer-rate tick enable, one system cycle wide |

## Verification
The assertions assume that the target tick rate is below half the system clock rate, so that carries never come on back-to-back cycles. The default parameters give roughly one tick every seventy cycles. The assertions also assume that bus requests are driven as clean single-cycle strobes synchronous to `clk`. The stimulus changes bus inputs only away from the active edge and keeps the parameters at their defaults. Its random configuration writes set the stop and hold bits only rarely, so that long counting stretches, wraps after presets near the top of each width, and width changes in the middle of a count all occur.

// File: rtl/pm_timer_pkg.sv
package pm_timer_pkg;

  localparam int CFG_BITS = 3;

  typedef struct packed {
    logic hold;   // bit 2: force count to zero
    logic stop;   // bit 1: freeze count
    logic wide;   // bit 0: 32-bit counting
  } tmr_cfg_t;

  // Rounded phase increment for an accumulator of acc_w bits.
  function automatic longint unsigned phase_inc(input longint unsigned sys_hz,
                                                input longint unsigned tick_hz,
                                                input int acc_w);
    longint unsigned num;
    num = (tick_hz << acc_w) + (sys_hz >> 1);
    return num / sys_hz;
  endfunction

endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
  parameter int              ACC_W     = 32,
  parameter logic [ACC_W-1:0] PHASE_INC = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             tick_q, tick_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, PHASE_INC};
    acc_d  = sum[ACC_W-1:0];
    tick_d = sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/pm_timer_cfg.sv
module pm_timer_cfg
  import pm_timer_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CFG_OFS = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CFG_BITS-1:0] wdata,
  output tmr_cfg_t            cfg_o
);
  tmr_cfg_t cfg_q, cfg_d;
  logic     cfg_we;

  always_comb begin
    cfg_we = wr_en && (addr == CFG_OFS);
    cfg_d  = cfg_q;
    if (cfg_we) cfg_d = tmr_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pm_timer_count.sv
module pm_timer_count
  import pm_timer_pkg::*;
#(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  tmr_cfg_t          cfg,
  input  logic              load,
  input  logic [WIDE_W-1:0] load_val,
  output logic [WIDE_W-1:0] cnt_o
);
  localparam logic [WIDE_W-1:0] NARROW_MASK =
    {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [WIDE_W-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    mask = cfg.wide ? '1 : NARROW_MASK;
    if (cfg.hold)
      cnt_d = '0;
    else if (load)
      cnt_d = load_val & mask;
    else if (tick && !cfg.stop)
      cnt_d = (cnt_q + 1'b1) & mask;
    else
      cnt_d = cnt_q & mask;  // truncates on a switch to narrow mode
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pm_acpi_timer.sv
module pm_acpi_timer
  import pm_timer_pkg::*;
#(
  parameter longint unsigned SYS_HZ      = 250_000_000,
  parameter longint unsigned TICK_HZ     = 3_579_545,
  parameter int              ACC_W       = 32,
  parameter int              ADDR_W      = 8,
  parameter int              WIDE_W      = 32,
  parameter int              NARROW_W    = 24,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CFG_OFS   = 8'h00,
  parameter logic [ADDR_W-1:0] CNT_OFS   = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDE_W-1:0] bus_wdata,
  output logic [WIDE_W-1:0] bus_rdata,
  output logic              tick_pulse
);
  localparam longint unsigned INC_L = phase_inc(SYS_HZ, TICK_HZ, ACC_W);
  localparam logic [ACC_W-1:0] PHASE_INC = INC_L[ACC_W-1:0];
  localparam logic [WIDE_W-1:0] NARROW_MASK =
    {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  // Reset: asserted asynchronously, released through a synchronizer chain.
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = sync_q[SYNC_STAGES-1];

  logic wr_en, rd_en, cnt_load;
  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign cnt_load = wr_en && (bus_addr == CNT_OFS);

  logic              tick;
  tmr_cfg_t          cfg;
  logic [WIDE_W-1:0] cnt;

  pm_tick_gen #(.ACC_W(ACC_W), .PHASE_INC(PHASE_INC)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .tick_o(tick)
  );

  pm_timer_cfg #(.ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata[CFG_BITS-1:0]), .cfg_o(cfg)
  );

  pm_timer_count #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .cfg(cfg),
    .load(cnt_load), .load_val(bus_wdata), .cnt_o(cnt)
  );

  // Read path
  logic [WIDE_W-1:0] rd_d, rd_q, view_mask;

  always_comb begin
    view_mask = cfg.wide ? '1 : NARROW_MASK;
    rd_d = rd_q;
    if (rd_en) begin
      if (bus_addr == CNT_OFS)
        rd_d = cnt & view_mask;
      else if (bus_addr == CFG_OFS)
        rd_d = {{(WIDE_W-CFG_BITS){1'b0}}, cfg};
      else
        rd_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_q <= '0;
    else            rd_q <= rd_d;
  end

  assign bus_rdata  = rd_q;
  assign tick_pulse = tick;
endmodule

// File: rtl/pm_acpi_timer_chk.sv
module pm_acpi_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [2:0]  cfg,
  input logic [31:0] cnt,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [31:0] bus_rdata
);
  logic any_wr;
  assign any_wr = bus_sel && bus_wr;

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[2] |=> (cnt == 32'd0));

  // R6
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1] && !cfg[2] && !any_wr && (cfg[0] || cnt[31:24] == 8'd0))
      |=> (cnt == $past(cnt)));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg[1] && !cfg[2] && !any_wr &&
     ((cfg[0] && cnt != 32'hFFFF_FFFF) ||
      (!cfg[0] && cnt[31:24] == 8'd0 && cnt[23:0] != 24'hFF_FFFF)))
      |=> (cnt == $past(cnt) + 32'd1));

  // R4
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[0] |=> (cnt[31:24] == 8'd0));

  // R9
  read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !cfg[0]) |=> (bus_rdata[31:24] == 8'd0));
endmodule

bind pm_acpi_timer pm_acpi_timer_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .tick(tick), .cfg(cfg), .cnt(cnt),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rdata(bus_rdata)
);

// File: tb/pm_acpi_timer_bench.sv
module pm_acpi_timer_bench;
  localparam real SYS_HZ  = 250_000_000.0;
  localparam real TICK_HZ = 3_579_545.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        tick_pulse;

  always #2 clk = ~clk;  // 250 MHz

  pm_acpi_timer u_pm_acpi_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_pulse(tick_pulse)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Bench model of the programmer-visible state
  logic [31:0] m_cnt = 0;
  logic [2:0]  m_cfg = 0;
  logic [31:0] last_rd = 0;
  int          m_ticks = 0;
  logic        prev_tick = 0;
  int          dbl_ticks = 0;

  function automatic logic [31:0] wmask(input logic wide);
    return wide ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
  endfunction

  function automatic logic [31:0] rd_expect(input logic [7:0] a);
    if (a == 8'h08) return m_cnt & wmask(m_cfg[0]);
    if (a == 8'h00) return {29'd0, m_cfg};
    return 32'd0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One bus cycle, started and ended at a falling edge.
  task automatic step(input logic s, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input string req);
    logic [31:0] exp_rd;
    logic        t, is_rd;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    t      = tick_pulse;
    is_rd  = s && !w;
    exp_rd = is_rd ? rd_expect(a) : last_rd;
    if (t && prev_tick) dbl_ticks++;
    prev_tick = t;
    if (t) m_ticks++;
    if (m_cfg[2])                      m_cnt = 32'd0;
    else if (s && w && a == 8'h08)     m_cnt = d & wmask(m_cfg[0]);
    else if (t && !m_cfg[1])           m_cnt = 32'(m_cnt + 32'd1) & wmask(m_cfg[0]);
    else                               m_cnt = m_cnt & wmask(m_cfg[0]);
    if (s && w && a == 8'h00) m_cfg = d[2:0];
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (is_rd) check(bus_rdata, exp_rd, req);
    last_rd = exp_rd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 32'h0, "idle");
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    step(1, 0, a, 32'h0, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1, 1, a, d, "write");
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    real exp_t;
    int  hold_steps;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(bus_rdata, 32'd0, "R1 rdata");
    idle(3);
    rd(8'h08, "R1 count");
    rd(8'h00, "R1 config");

    // R2 / R3: tick rate and counting from reset
    m_ticks = 0;
    idle(20000);
    exp_t = 20000.0 * TICK_HZ / SYS_HZ;
    n_chk++;
    if ((real'(m_ticks) - exp_t) > 2.0 || (exp_t - real'(m_ticks)) > 2.0) begin
      n_fail++;
      $display("FAIL R2 rate: actual %0d expected %0f", m_ticks, exp_t);
    end
    rd(8'h08, "R3 count equals ticks");

    // R4 / R10: narrow wrap after preset (upper preset bits dropped)
    wr(8'h08, 32'h55FF_FFFD);
    rd(8'h08, "R10 narrow preset");
    idle(400);
    rd(8'h08, "R4 narrow wrap");
    n_chk++;
    if (bus_rdata >= 32'h100) begin
      n_fail++;
      $display("FAIL R4: actual 0x%08h expected below 0x100", bus_rdata);
    end

    // R5: wide wrap
    wr(8'h00, 32'h1);
    rd(8'h00, "R9 config readback");
    wr(8'h08, 32'h12FF_FFFF);
    rd(8'h08, "R5 wide preset");
    wr(8'h08, 32'hFFFF_FFFE);
    idle(400);
    rd(8'h08, "R5 wide wrap");

    // R8: truncation on switch to narrow mode
    wr(8'h08, 32'hABCD_EF12);
    wr(8'h00, 32'h0);
    rd(8'h08, "R8 truncated count");
    check(bus_rdata[31:24], 8'h00, "R8 upper zero");

    // R6: stop
    wr(8'h00, 32'h2);
    rd(8'h08, "R6 stopped before");
    idle(500);
    rd(8'h08, "R6 stopped after");
    wr(8'h08, 32'h0000_0777);
    idle(300);
    rd(8'h08, "R10 load while stopped");

    // R7: hold, write ignored, restart from zero
    wr(8'h00, 32'h4);
    idle(2);
    wr(8'h08, 32'h00AB_CDEF);
    rd(8'h08, "R7 R10 held at zero");
    wr(8'h00, 32'h0);
    hold_steps = 0;
    while (!tick_pulse && hold_steps < 200) begin
      rd(8'h08, "R7 zero before tick");
      hold_steps++;
    end
    idle(1);
    rd(8'h08, "R7 first count");
    check(bus_rdata, 32'd1, "R7 one after release");

    // R9 / R10: unmapped offsets
    rd(8'h04, "R9 unmapped read");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h00, "R10 unmapped write ignored");
    idle(5);
    check(bus_rdata, last_rd, "R9 read data holds");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 100;
      if (r < 45)      idle(1 + ($urandom % 40));
      else if (r < 70) rd(8'h08, "R3 R4 R5 random count read");
      else if (r < 78) rd(8'h00, "R9 random config read");
      else if (r < 84) begin
        logic [2:0] c = 3'($urandom % 2);
        if (($urandom % 8) == 0) c[1] = 1'b1;
        if (($urandom % 12) == 0) c[2] = 1'b1;
        wr(8'h00, {29'd0, c});
      end
      else if (r < 91) begin
        logic [31:0] v = $urandom;
        if ($urandom % 2) v[23:0] = 24'hFF_FFF0 | 24'($urandom % 16);
        wr(8'h08, v);
      end
      else if (r < 95) rd(8'($urandom % 256) | 8'h20, "R9 random unmapped read");
      else             wr(8'($urandom % 256) | 8'h20, $urandom);
      if (i % 97 == 0) begin
        idle(1);
        check(bus_rdata, last_rd, "R9 random hold");
      end
    end

    check(32'(dbl_ticks), 32'd0, "R2 no back-to-back ticks");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule